// File: doc/BRIEF.md
# Keyed Watchdog Timer with Interrupt-then-Reset Escalation

This block is a watchdog timer. Software writes one control register that holds a 7-bit key, an arm/run bit and an 8-bit start count. Once the watchdog is armed, a new control write is obeyed only if its key is the bitwise inverse of the key already stored. A stray or runaway write that does not know the current key therefore cannot stop or reload the timer. Each accepted write reloads the counter, clears any escalation and either starts or stops the countdown.

The counter steps down once for every cycle in which the slow tick-enable input is high, nominally about 760 times a second. The block escalates in two stages. The first expiry raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before an accepted write arrives, the block emits a one-cycle system reset request. A status register reports the live count, whether the counter is running and how far escalation has gone.

The controller is a five-state machine:
- IDLE: stopped.
- RUN: normal countdown.
- GRACE: interrupt raised, grace countdown.
- BITE: one cycle of reset request.
- SPENT: stopped, interrupt still high.

It has these transitions:
- Any accepted write: to RUN if the run bit is set, to IDLE if it is clear.
- RUN to GRACE on the first expiry.
- GRACE to BITE on the second expiry.
- BITE to SPENT unconditionally.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the stored control value reads as zero, the counter is stopped at 0, the interrupt is low and the reset request is low.
- R2: The control register sits at offset 0x40 and the status register at 0x44. The control fields are key [15:9], run/arm bit [8] and start count [7:0]. Reading 0x40 returns the stored bits [15:0] with bits [31:16] zero.
- R3: While the stored bit 8 is 1, a control write is discarded unless its key [15:9] equals the bitwise inverse of the stored key. A discarded write changes nothing. While the stored bit 8 is 0, any key is accepted.
- R4: An accepted write loads the counter from the start count. A start count of 0 loads 256.
- R5: An accepted write with bit 8 set starts the countdown. With bit 8 clear it stops the countdown, and the counter holds its loaded value.
- R6: While running, the counter drops by one in each cycle in which tick_en is high. Ticks have no effect while the counter is stopped.
- R7: A tick that arrives with the count at 1 in the normal stage raises nmi. It also reloads the counter with GRACE_TICKS, and the countdown continues.
- R8: A tick that arrives with the count at 1 in the grace stage produces exactly one cycle of reset_req and stops the counter at 0. nmi stays high until an accepted write.
- R9: An accepted write returns the expiry stage to none and drops nmi.
- R10: An accepted write in the same cycle as a tick takes precedence over the decrement and over any expiry.
- R11: The status register at 0x44 has count in [8:0], running in [12] and stage in [17:16], with all other bits zero. Stage encodings are 0 for none, 1 for interrupt raised and 2 for reset issued. Writes to 0x44 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow prescaled tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 32 | Read data (combinational) |
| nmi | output | 1 | Non-maskable interrupt level |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A control write and a tick can arrive in the same cycle. The hardest such cycle is the one in which the tick would expire the counter. The bench puts a correctly keyed write into exactly the cycle in which the count sits at 1 and tick_en is high. It then judges that the reload value appears in the status register, with stage 0 and nmi low, rather than the grace value or a raised interrupt. It also pairs a wrongly keyed write with a tick, to show that the decrement proceeds while the write is lost.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_GRACE = 3'd2,
        ST_BITE  = 3'd3,
        ST_SPENT = 3'd4
    } wd_state_e;

    localparam int KEY_W      = 7;
    localparam int KEY_LSB    = 9;
    localparam int CMD_BIT    = 8;
    localparam int CTRL_W     = KEY_LSB + KEY_W;
    localparam int RUN_BIT    = 12;
    localparam int STAGE_LSB  = 16;

    localparam logic [1:0] STAGE_NONE  = 2'd0;
    localparam logic [1:0] STAGE_NMI   = 2'd1;
    localparam logic [1:0] STAGE_RESET = 2'd2;

endpackage

// File: rtl/kwd_key_guard.sv
module kwd_key_guard
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [31:0]       wr_data,
    output logic              accept,
    output logic [CTRL_W-1:0] ctrl_q
);

    logic [KEY_W-1:0] held_key;
    logic             armed;

    assign held_key = ctrl_q[KEY_LSB +: KEY_W];
    assign armed    = ctrl_q[CMD_BIT];
    assign accept   = wr_stb && (!armed || (wr_data[KEY_LSB +: KEY_W] == ~held_key));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (accept)
            ctrl_q <= wr_data[CTRL_W-1:0];
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    assign expire = dec && (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - CNT_W'(1);
    end

endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       cmd_run,
    input  logic       expire,
    output logic       load_grace,
    output logic       running,
    output logic       nmi,
    output logic       reset_req,
    output logic [1:0] stage
);

    wd_state_e state, nxt;

    always_comb begin
        nxt = state;
        if (accept) begin
            nxt = cmd_run ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_RUN:   nxt = expire ? ST_GRACE : ST_RUN;
                ST_GRACE: nxt = expire ? ST_BITE : ST_GRACE;
                ST_BITE:  nxt = ST_SPENT;
                ST_SPENT: nxt = ST_SPENT;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        load_grace = !accept && (state == ST_RUN) && expire;
        running    = 1'b0;
        nmi        = 1'b0;
        reset_req  = 1'b0;
        stage      = STAGE_NONE;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:   running = 1'b1;
            ST_GRACE: begin
                running = 1'b1;
                nmi     = 1'b1;
                stage   = STAGE_NMI;
            end
            ST_BITE: begin
                nmi       = 1'b1;
                reset_req = 1'b1;
                stage     = STAGE_RESET;
            end
            ST_SPENT: begin
                nmi   = 1'b1;
                stage = STAGE_RESET;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  CTRL_OFS    = 8'h40,
    parameter logic [7:0]  STAT_OFS    = 8'h44,
    parameter int          FIELD_W     = 8,
    parameter int          GRACE_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              nmi,
    output logic              reset_req
);

    localparam int CNT_W = FIELD_W + 1;

    logic              wr_stb;
    logic              accept;
    logic [CTRL_W-1:0] ctrl_q;
    logic              load_grace;
    logic              running;
    logic [1:0]        stage;
    logic [CNT_W-1:0]  cnt;
    logic              expire;
    logic [CNT_W-1:0]  start_val;
    logic [CNT_W-1:0]  load_val;
    logic [31:0]       status;

    assign wr_stb = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

    kwd_key_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .accept  (accept),
        .ctrl_q  (ctrl_q)
    );

    assign start_val = (wr_data[FIELD_W-1:0] == '0) ? CNT_W'(1 << FIELD_W)
                                                     : {1'b0, wr_data[FIELD_W-1:0]};
    assign load_val  = accept ? start_val : CNT_W'(GRACE_TICKS);

    kwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept || load_grace),
        .load_val (load_val),
        .dec      (tick_en && running),
        .cnt      (cnt),
        .expire   (expire)
    );

    kwd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cmd_run    (wr_data[CMD_BIT]),
        .expire     (expire),
        .load_grace (load_grace),
        .running    (running),
        .nmi        (nmi),
        .reset_req  (reset_req),
        .stage      (stage)
    );

    always_comb begin
        status                       = '0;
        status[CNT_W-1:0]            = cnt;
        status[RUN_BIT]              = running;
        status[STAGE_LSB +: 2]       = stage;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_OFS))
            rd_data[CTRL_W-1:0] = ctrl_q;
        else if (rd_addr == ADDR_W'(STAT_OFS))
            rd_data = status;
    end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int FIELD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [31:0]       wr_data,
    input logic              accept,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              running,
    input logic [CNT_W-1:0]  cnt,
    input logic              nmi,
    input logic              reset_req
);

    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_req_after_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(nmi));

    assert_bad_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ctrl_q[CMD_BIT] && (wr_data[KEY_LSB +: KEY_W] != ~ctrl_q[KEY_LSB +: KEY_W]))
        |=> $stable(ctrl_q));

    assert_nmi_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !nmi);

    assert_run_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (running == $past(wr_data[CMD_BIT])));

    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !accept) |=> $stable(cnt));

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(1 << FIELD_W));

endmodule

bind keyed_watchdog kwd_checker #(.CNT_W(CNT_W), .FIELD_W(FIELD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .accept    (accept),
    .ctrl_q    (ctrl_q),
    .running   (running),
    .cnt       (cnt),
    .nmi       (nmi),
    .reset_req (reset_req)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;

    localparam int G = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h44;
    logic [31:0] rd_data;
    logic        nmi;
    logic        reset_req;

    always #2 clk = ~clk;

    keyed_watchdog #(.GRACE_TICKS(G)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .nmi       (nmi),
        .reset_req (reset_req)
    );

    typedef struct {
        string       tag;
        logic        nmi;
        logic        req;
        logic [31:0] stat;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0]  m_key;
    logic        m_en;
    logic [15:0] m_ctrl;
    int          m_cnt;
    logic        m_run;
    int          m_stage;
    logic        m_req;

    function automatic logic [31:0] wd(input logic [6:0] key, input logic cmd, input logic [7:0] c);
        return {16'h0, key, cmd, c};
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        s[8:0]   = m_cnt[8:0];
        s[12]    = m_run;
        s[17:16] = m_stage[1:0];
        return s;
    endfunction

    task automatic model_reset();
        m_key = '0; m_en = 1'b0; m_ctrl = '0; m_cnt = 0;
        m_run = 1'b0; m_stage = 0; m_req = 1'b0;
    endtask

    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic tk, input string tag);
        exp_t e;
        logic acc;
        wr_en = wr; wr_addr = a; wr_data = d; tick_en = tk;
        m_req = 1'b0;
        acc = wr && (a == 8'h40) && (!m_en || (d[15:9] == ~m_key));
        if (acc) begin
            m_key = d[15:9]; m_en = d[8]; m_ctrl = d[15:0];
            m_cnt = (d[7:0] == 8'h00) ? 256 : int'(d[7:0]);
            m_run = d[8]; m_stage = 0;
        end else if (tk && m_run) begin
            if (m_cnt == 1) begin
                if (m_stage == 0) begin
                    m_stage = 1; m_cnt = G;
                end else begin
                    m_stage = 2; m_cnt = 0; m_run = 1'b0; m_req = 1'b1;
                end
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        e.tag = tag; e.nmi = (m_stage != 0); e.req = m_req; e.stat = m_status();
        @(posedge clk);
        #1;
        q.push_back(e);
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (nmi !== e.nmi || reset_req !== e.req || rd_data !== e.stat) begin
                errors++;
                $display("FAIL %s: got nmi=%b req=%b stat=%h expected nmi=%b req=%b stat=%h",
                         e.tag, nmi, reset_req, rd_data, e.nmi, e.req, e.stat);
            end
        end
    end

    task automatic check_ctrl(input string tag);
        logic [31:0] exp_v;
        #1;
        rd_addr = 8'h40;
        #0.5;
        exp_v = {16'h0, m_ctrl};
        checks++;
        if (rd_data !== exp_v) begin
            errors++;
            $display("FAIL %s: control readback got %h expected %h", tag, rd_data, exp_v);
        end
        rd_addr = 8'h44;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 8'h00, '0, 1'b0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        do_reset("R1 reset state");
        check_ctrl("R1 control cleared");

        // R2 R4 R5: arm with key 0x15, count 3
        step(1'b1, 8'h40, wd(7'h15, 1'b1, 8'd3), 1'b0, "R2 R5 start");
        check_ctrl("R2 control readback");
        step(1'b0, 8'h00, '0, 1'b1, "R6 tick");
        step(1'b0, 8'h00, '0, 1'b1, "R6 tick");
        step(1'b0, 8'h00, '0, 1'b0, "R6 no tick holds");
        step(1'b0, 8'h00, '0, 1'b1, "R7 first expiry");
        step(1'b1, 8'h40, wd(7'h15, 1'b0, 8'd5), 1'b0, "R3 wrong key dropped");
        step(1'b0, 8'h00, '0, 1'b1, "R8 second expiry");
        step(1'b0, 8'h00, '0, 1'b0, "R8 pulse ends");
        step(1'b0, 8'h00, '0, 1'b1, "R8 stopped after bite");
        step(1'b1, 8'h44, wd(7'h6A, 1'b0, 8'd9), 1'b0, "R11 status write ignored");
        step(1'b1, 8'h40, wd(7'h6A, 1'b0, 8'd0), 1'b0, "R9 R4 clear and 256");
        step(1'b0, 8'h00, '0, 1'b1, "R5 stopped ignores tick");
        step(1'b0, 8'h00, '0, 1'b1, "R6 stopped ignores tick");

        // disarmed: any key accepted
        step(1'b1, 8'h40, wd(7'h33, 1'b1, 8'd2), 1'b0, "R3 disarmed accepts");
        step(1'b0, 8'h00, '0, 1'b1, "R6 tick");
        step(1'b1, 8'h40, wd(7'h4C, 1'b1, 8'd5), 1'b1, "R10 write beats expiry");
        step(1'b1, 8'h40, wd(7'h4C, 1'b1, 8'd9), 1'b1, "R3 bad key with tick");
        for (int i = 0; i < 4; i++)
            step(1'b0, 8'h00, '0, 1'b1, "R7 run down");
        step(1'b1, 8'h40, wd(7'h33, 1'b1, 8'd0), 1'b0, "R9 kick clears nmi");
        for (int i = 0; i < 256; i++)
            step(1'b0, 8'h00, '0, 1'b1, "R4 full 256 count");
        check_ctrl("R2 readback armed");

        do_reset("R1 reset mid run");
        check_ctrl("R1 control cleared again");
        step(1'b0, 8'h00, '0, 1'b1, "R1 stays stopped");

        @(negedge clk);
        finish_run();
    end

endmodule